// File: doc/BRIEF.md
# Grey-scale palette pixel mapper

This block turns one line of display memory into on/off drive values for the columns of a four-level grey-scale panel. Each memory byte carries four pixels as 2-bit codes. Every code is converted to a 5-bit brightness level, either through four writable palette entries or through a fixed ramp. A frame-phase PWM then decides whether the column is lit in the current frame.

The line is presented as a flat vector of bytes, and one registered column vector comes out one clock later. Palette writes go into a staging copy. That copy is committed to the working palette only on a frame boundary, so a frame is never drawn with a mix of old and new shades.

Output-side controls can invert the image, blank the panel, or mirror the column order so that the first memory byte drives the last column.

Top module: `gpm_top`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `col_on` is all zero and `phase_o` is 0. Reset loads the staging and working palette entries for codes 0,1,2,3 with 0,10,21,31.
- R2: Each cycle with `frame_tick` high advances `phase_o` by one, wrapping from 31 to 0. Without `frame_tick` the phase holds.
- R3: With `flip_en` low, column 4*b+p takes its code from byte b (`line_data[8b+7:8b]`), bits [7-2p:6-2p]. The higher-numbered bit is the code MSB, so the leftmost pixel is bits 7:6.
- R4: With `grey_en` low, codes 00, 01, 10 and 11 map to levels 0, 10, 21 and 31, and the palette has no effect.
- R5: With `grey_en` high, the level of a column is the working palette entry selected by its code.
- R6: A column is lit when the phase is strictly less than its level. Level 0 is never lit, and level 31 is lit in every phase except 31.
- R7: With `rev_en` high, every column value is inverted.
- R8: With `disp_on` low, every column is 0 whatever the other controls are, including `rev_en`.
- R9: With `flip_en` high, column c shows the pixel that column NUM_COLS-1-c shows with `flip_en` low. This reverses both the byte order and the pixel order inside each byte, while each code keeps its bit significance.
- R10: `pal_we` writes `pal_level` into staging entry `pal_sel`. The working palette copies the staging palette only in a `frame_tick` cycle. A write in the same cycle as a tick is committed at the following tick.
- R11: `col_on` is registered. It reflects the line data, controls, phase and working palette present in the cycle before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | Frame boundary: advance phase, commit palette |
| pal_we | input | 1 | Palette staging write enable |
| pal_sel | input | 2 | Code whose palette entry is written |
| pal_level | input | 5 | Level written to the staging entry |
| grey_en | input | 1 | 1: use palette, 0: fixed ramp |
| rev_en | input | 1 | Invert the image |
| flip_en | input | 1 | Mirror column order |
| disp_on | input | 1 | 0 blanks all columns |
| line_data | input | LINE_BYTES*8 | Memory line, byte b at bits [8b+7:8b] |
| phase_o | output | 5 | Current frame phase |
| col_on | output | LINE_BYTES*4 | Registered column drive values |

## Verification
On every cycle, assertions check the following:
- The phase advances or holds according to the tick (R2).
- The working palette changes only at a tick, and staging writes land in the selected entry (R10).
- Blanking forces the outputs to zero (R8).
- In fixed mode, the darkest and brightest codes give the correct levels (R4).

Some behaviour shows only in the bench's scenarios, where a reference model computes whole column vectors:
- The column mapping under both orderings (R3, R9).
- The full palette lookup (R5).
- Thresholds at specific phases (R6).
- Inversion (R7).
- The deferred commit of a write that collides with a tick (R10).

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int CODE_W       = 2;
  localparam int LVL_W        = 5;
  localparam int NUM_CODES    = 1 << CODE_W;
  localparam int PIX_PER_BYTE = 8 / CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LVL_W-1:0]  level_t;

  // Fixed grey ramp used when the palette is bypassed.
  function automatic level_t ramp_level(code_t c);
    level_t l;
    case (c)
      2'd0:    l = 5'd0;
      2'd1:    l = 5'd10;
      2'd2:    l = 5'd21;
      default: l = 5'd31;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/gpm_palette.sv
module gpm_palette
  import gpm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_tick,
  input  logic                        wr_en,
  input  code_t                       wr_sel,
  input  level_t                      wr_level,
  output logic [NUM_CODES*LVL_W-1:0]  act_flat
);
  level_t stage_q [NUM_CODES];
  level_t stage_d [NUM_CODES];
  level_t act_q   [NUM_CODES];
  level_t act_d   [NUM_CODES];

  always_comb begin
    for (int k = 0; k < NUM_CODES; k++) begin
      stage_d[k] = stage_q[k];
      act_d[k]   = act_q[k];
      if (wr_en && (wr_sel == code_t'(k))) stage_d[k] = wr_level;
      if (frame_tick) act_d[k] = stage_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CODES; k++) begin
        stage_q[k] <= ramp_level(code_t'(k));
        act_q[k]   <= ramp_level(code_t'(k));
      end
    end else begin
      for (int k = 0; k < NUM_CODES; k++) begin
        stage_q[k] <= stage_d[k];
        act_q[k]   <= act_d[k];
      end
    end
  end

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_entry
    assign act_flat[k*LVL_W +: LVL_W] = act_q[k];

    assert_stage_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == code_t'(k)) |=> stage_q[k] == $past(wr_level));
  end

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_flat));
endmodule

// File: rtl/gpm_unpack.sv
module gpm_unpack
  import gpm_pkg::*;
#(
  parameter int LINE_BYTES = 4,
  localparam int NUM_COLS  = LINE_BYTES * PIX_PER_BYTE
) (
  input  logic [LINE_BYTES*8-1:0]     line_data,
  input  logic                        flip_en,
  output logic [NUM_COLS*CODE_W-1:0]  codes_flat
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int POS_N = c;
    localparam int POS_F = NUM_COLS - 1 - c;
    localparam int HI_N  = (POS_N / PIX_PER_BYTE) * 8 + 7 - CODE_W * (POS_N % PIX_PER_BYTE);
    localparam int HI_F  = (POS_F / PIX_PER_BYTE) * 8 + 7 - CODE_W * (POS_F % PIX_PER_BYTE);
    assign codes_flat[c*CODE_W +: CODE_W] =
      flip_en ? line_data[HI_F -: CODE_W] : line_data[HI_N -: CODE_W];
  end
endmodule

// File: rtl/gpm_cell.sv
module gpm_cell
  import gpm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  code_t                       code,
  input  logic [NUM_CODES*LVL_W-1:0]  pal_flat,
  input  logic                        grey_en,
  input  level_t                      phase,
  input  logic                        rev_en,
  input  logic                        disp_on,
  output logic                        col_q
);
  level_t level;
  logic   lit;
  logic   col_d;

  always_comb begin
    level = grey_en ? pal_flat[int'(code)*LVL_W +: LVL_W] : ramp_level(code);
    lit   = (phase < level);
    col_d = disp_on & (lit ^ rev_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= 1'b0;
    else        col_q <= col_d;
  end

  assert_fixed_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !grey_en && !rev_en && code == 2'b00) |=> !col_q);

  assert_fixed_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !grey_en && !rev_en && code == 2'b11 && phase != 5'd31) |=> col_q);
endmodule

// File: rtl/gpm_top.sv
module gpm_top
  import gpm_pkg::*;
#(
  parameter int LINE_BYTES = 4,
  localparam int NUM_COLS  = LINE_BYTES * PIX_PER_BYTE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_tick,
  input  logic                      pal_we,
  input  logic [1:0]                pal_sel,
  input  logic [4:0]                pal_level,
  input  logic                      grey_en,
  input  logic                      rev_en,
  input  logic                      flip_en,
  input  logic                      disp_on,
  input  logic [LINE_BYTES*8-1:0]   line_data,
  output logic [4:0]                phase_o,
  output logic [NUM_COLS-1:0]       col_on
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  // Frame phase counter.
  level_t phase_q, phase_d;
  always_comb phase_d = frame_tick ? phase_q + LVL_W'(1) : phase_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) phase_q <= '0;
    else        phase_q <= phase_d;
  end
  assign phase_o = phase_q;

  logic [NUM_CODES*LVL_W-1:0] pal_flat;
  logic [NUM_COLS*CODE_W-1:0] codes_flat;

  gpm_palette u_pal (
    .clk        (clk),
    .rst_n      (rst_s),
    .frame_tick (frame_tick),
    .wr_en      (pal_we),
    .wr_sel     (pal_sel),
    .wr_level   (pal_level),
    .act_flat   (pal_flat)
  );

  gpm_unpack #(.LINE_BYTES(LINE_BYTES)) u_unpack (
    .line_data  (line_data),
    .flip_en    (flip_en),
    .codes_flat (codes_flat)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_cell
    gpm_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_s),
      .code     (codes_flat[c*CODE_W +: CODE_W]),
      .pal_flat (pal_flat),
      .grey_en  (grey_en),
      .phase    (phase_q),
      .rev_en   (rev_en),
      .disp_on  (disp_on),
      .col_q    (col_on[c])
    );
  end

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !frame_tick |=> $stable(phase_o));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_s)
    frame_tick |=> phase_o == $past(phase_o) + 5'd1);

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !disp_on |=> col_on == '0);
endmodule

// File: tb/gpm_top_tb.sv
module gpm_top_tb;
  localparam int NB = 4;
  localparam int NC = NB * 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_tick, pal_we, grey_en, rev_en, flip_en, disp_on;
  logic [1:0]    pal_sel;
  logic [4:0]    pal_level;
  logic [NB*8-1:0] line_data;
  logic [4:0]    phase_o;
  logic [NC-1:0] col_on;

  always #2 clk = ~clk;

  gpm_top #(.LINE_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pal_we(pal_we),
    .pal_sel(pal_sel), .pal_level(pal_level), .grey_en(grey_en),
    .rev_en(rev_en), .flip_en(flip_en), .disp_on(disp_on),
    .line_data(line_data), .phase_o(phase_o), .col_on(col_on)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [4:0] m_phase;
  logic [4:0] m_stage [4];
  logic [4:0] m_act   [4];

  function automatic logic [4:0] fixed_of(logic [1:0] c);
    case (c)
      2'd0: return 5'd0;
      2'd1: return 5'd10;
      2'd2: return 5'd21;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [NC-1:0] model_cols(logic [NB*8-1:0] ln, logic f, logic g,
                                               logic r, logic d, logic [4:0] ph);
    logic [NC-1:0] res;
    for (int c = 0; c < NC; c++) begin
      int pos, b, p;
      logic [1:0] code;
      logic [4:0] lvl;
      logic on;
      pos  = f ? NC - 1 - c : c;
      b    = pos / 4;
      p    = pos % 4;
      code = {ln[b*8 + 7 - 2*p], ln[b*8 + 6 - 2*p]};
      lvl  = g ? m_act[code] : fixed_of(code);
      on   = (ph < lvl) ^ r;
      res[c] = d & on;
    end
    return res;
  endfunction

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [NC-1:0] last_exp;

  task automatic step(logic tk, logic we, logic [1:0] sel, logic [4:0] lv, logic g,
                      logic r, logic f, logic d, logic [NB*8-1:0] ln, string req);
    @(negedge clk);
    frame_tick = tk; pal_we = we; pal_sel = sel; pal_level = lv;
    grey_en = g; rev_en = r; flip_en = f; disp_on = d; line_data = ln;
    last_exp = model_cols(ln, f, g, r, d, m_phase);
    @(posedge clk);
    if (tk) begin
      for (int k = 0; k < 4; k++) m_act[k] = m_stage[k];
      m_phase = m_phase + 5'd1;
    end
    if (we) m_stage[sel] = lv;
    #1;
    check_eq({req, " cols (R11)"}, 32'(col_on), 32'(last_exp));
    check_eq("R2 phase", 32'(phase_o), 32'(m_phase));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    rst_n = 1'b0;
    frame_tick = 0; pal_we = 0; pal_sel = 0; pal_level = 0;
    grey_en = 0; rev_en = 0; flip_en = 0; disp_on = 0; line_data = '0;
    m_phase = 0;
    for (int k = 0; k < 4; k++) begin
      m_stage[k] = fixed_of(2'(k));
      m_act[k]   = fixed_of(2'(k));
    end
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1 reset cols", 32'(col_on), 32'd0);
    check_eq("R1 reset phase", 32'(phase_o), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1 post-release cols", 32'(col_on), 32'd0);

    // R3: byte0 = 11 10 01 00, fixed ramp, phase 0
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h000000E4, "R3");
    check_eq("R3 unpack", 32'(col_on), 32'h0007);
    // R9: mirrored
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h000000E4, "R9");
    check_eq("R9 flip", 32'(col_on), 32'hE000);
    // R7: reversed
    step(0, 0, 0, 0, 0, 1, 0, 1, 32'h000000E4, "R7");
    check_eq("R7 reverse", 32'(col_on), 32'hFFF8);
    // R8: blank overrides reverse
    step(0, 0, 0, 0, 0, 1, 0, 0, 32'h000000E4, "R8");
    check_eq("R8 blank", 32'(col_on), 32'h0000);

    // R4: palette ignored in fixed mode; stage code 0 as 31 and commit
    step(1, 1, 2'd0, 5'd31, 0, 0, 0, 1, 32'h0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, 1, 32'h0, "R4");
    check_eq("R4 palette ignored", 32'(col_on), 32'h0000);
    // R5: palette now has code 0 = 31, phase 2
    step(0, 0, 0, 0, 1, 0, 0, 1, 32'h0, "R5");
    check_eq("R5 palette used", 32'(col_on), 32'hFFFF);

    // R10: write code 0 = 0, not visible until a tick
    step(0, 1, 2'd0, 5'd0, 1, 0, 0, 1, 32'h0, "R10");
    step(0, 0, 0, 0, 1, 0, 0, 1, 32'h0, "R10");
    check_eq("R10 before commit", 32'(col_on), 32'hFFFF);
    // collision: write 31 together with a tick -> commits 0
    step(1, 1, 2'd0, 5'd31, 1, 0, 0, 1, 32'h0, "R10");
    step(0, 0, 0, 0, 1, 0, 0, 1, 32'h0, "R10");
    check_eq("R10 commit old staging", 32'(col_on), 32'h0000);
    step(1, 0, 0, 0, 1, 0, 0, 1, 32'h0, "R10");
    step(0, 0, 0, 0, 1, 0, 0, 1, 32'h0, "R10");
    check_eq("R10 collided write committed", 32'(col_on), 32'hFFFF);

    // R6: walk phase to 20 and 21 with fixed ramp
    while (m_phase != 5'd20) step(1, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h000000E4, "R6");
    check_eq("R6 phase20", 32'(col_on), 32'h0003);
    step(1, 0, 0, 0, 0, 0, 0, 1, 32'h000000E4, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h000000E4, "R6");
    check_eq("R6 phase21", 32'(col_on), 32'h0001);
    // R2 wrap and R6 level 31 off at phase 31
    while (m_phase != 5'd31) step(1, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFFFFFF, "R6");
    check_eq("R6 full level at phase31", 32'(col_on), 32'h0000);
    step(1, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R2");
    check_eq("R2 wrap", 32'(phase_o), 32'd0);

    // Random mix of R3/R5/R6/R7/R9/R10
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) == 0, ($urandom % 4) == 0, 2'($urandom), 5'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
           32'($urandom), "random R5/R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule